// File: doc/BRIEF.md
# Tamper Input Event Detector

This block watches a single external tamper pin and reports intrusion attempts through a sticky detection flag and a maskable interrupt. It brings the pin into the core clock through a synchroniser. It then qualifies the pin in one of two ways, chosen by a 2-bit filter setting.

With the filter at zero the block acts on a transition of the pin. With a nonzero filter it acts only on a level that stays active for a run of consecutive samples taken on a sample strobe. A single trigger bit picks the direction in both cases, but its meaning depends on the mode. In edge mode it selects a rising or a falling transition. In level mode it selects a sustained low or a sustained high.

Software enables detection, polls or takes the interrupt, and clears the flag with a one-cycle pulse. Software must drop the enable before it flips the trigger bit in edge mode. Otherwise the polarity change itself can look like an edge.

Top module: `tamper_detect`

## Requirements
- R1: After reset (rst_ni low), flag_o and irq_o are 0.
- R2: While enable_i is 0, no detection event occurs and flag_o keeps its value whatever pin_i, sample_i and the other controls do.
- R3: With filt_i = 0 and trig_i = 0, a rising transition of pin_i sets flag_o; a falling transition does not.
- R4: With filt_i = 0 and trig_i = 1, a falling transition of pin_i sets flag_o; a rising transition does not.
- R5: With filt_i != 0 and trig_i = 0, the pin held low is the active level. Sampled high, it resets the run.
- R6: With filt_i != 0 and trig_i = 1, the pin held high is the active level. Sampled low, it resets the run.
- R7: In level mode, filt_i values 1, 2 and 3 need 2, 4 and 8 consecutive active samples. A sample is taken on a clock where sample_i = 1. The event fires on the sample that completes the run, and again on every later active sample until the run breaks.
- R8: flag_o is sticky. It is set on the clock after an event and cleared by a one-cycle clear_i pulse. An event in the same cycle as clear_i wins, and the flag stays 1.
- R9: irq_o equals flag_o AND irq_en_i. irq_en_i has no effect on whether flag_o is set.
- R10: pin_i passes through a two-flop synchroniser. A rising edge of pin_i that is stable before clock edge k sets flag_o at edge k+2 in edge mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | 1 | Asynchronous tamper pin |
| sample_i | input | 1 | Sample strobe for level filtering |
| enable_i | input | 1 | Detection enable |
| trig_i | input | 1 | Trigger polarity (edge direction or active level) |
| filt_i | input | 2 | Filter setting; 0 selects edge mode |
| irq_en_i | input | 1 | Interrupt enable |
| clear_i | input | 1 | One-cycle flag clear |
| flag_o | output | 1 | Sticky detection flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions take for granted that clear_i is a single-cycle pulse. They also assume that trig_i and filt_i change only while enable_i is low, so that a polarity flip is never seen as an edge. The random stimulus follows both rules. It lowers enable_i for at least one cycle around every change to trig_i or filt_i, and it holds clear_i for one clock only. Directed sequences cover the boundaries: the exact synchroniser latency, the run lengths of 2, 4 and 8 samples, a run broken by one inactive sample, and an event that lands on the same cycle as a clear.

// File: rtl/tamper_pkg.sv
package tamper_pkg;
  localparam int unsigned FILT_W = 2;
  localparam int unsigned CNT_W  = 2 ** FILT_W;

  typedef enum logic {
    MODE_EDGE  = 1'b0,
    MODE_LEVEL = 1'b1
  } tamper_mode_e;
endpackage

// File: rtl/tamper_sync.sv
module tamper_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] stage_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q <= '0;
        else         stage_q <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q <= '0;
        else         stage_q <= {stage_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];

  // R10: output is the input delayed by STAGES clocks
  a_r10_sync_delay: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stage_q[0]) |-> !q_o || (STAGES == 1));
endmodule

// File: rtl/tamper_qual.sv
module tamper_qual
  import tamper_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pin_s_i,
  input  logic              sample_i,
  input  logic              enable_i,
  input  logic              trig_i,
  input  logic [FILT_W-1:0] filt_i,
  output logic              evt_o
);
  tamper_mode_e     mode;
  logic             prev_q;
  logic             edge_hit;
  logic             active_lvl;
  logic [CNT_W-1:0] need;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_inc;
  logic             run_done;
  logic             lvl_hit;

  assign mode = (filt_i == '0) ? MODE_EDGE : MODE_LEVEL;

  // previous synchronised level, tracked regardless of enable
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= pin_s_i;
  end

  // trig 0: rising, trig 1: falling
  assign edge_hit = trig_i ? (prev_q & ~pin_s_i) : (~prev_q & pin_s_i);

  // level mode: trig 0 active low, trig 1 active high
  assign active_lvl = (pin_s_i == trig_i);
  assign need       = CNT_W'(1) << filt_i;
  assign cnt_inc    = cnt_q + CNT_W'(1);
  assign run_done   = (cnt_inc >= need);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (!enable_i || mode == MODE_EDGE) begin
      cnt_q <= '0;
    end else if (sample_i) begin
      if (!active_lvl)      cnt_q <= '0;
      else if (cnt_q < need) cnt_q <= cnt_inc;
    end
  end

  assign lvl_hit = sample_i & active_lvl & run_done;

  always_comb begin
    evt_o = 1'b0;
    if (enable_i) begin
      unique case (mode)
        MODE_EDGE:  evt_o = edge_hit;
        MODE_LEVEL: evt_o = lvl_hit;
        default:    evt_o = 1'b0;
      endcase
    end
  end

  a_r2_no_evt_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |-> !evt_o);
  a_r7_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= need || $changed(filt_i));
  a_r7_break_resets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_i && !active_lvl) |=> cnt_q == '0);
  a_r3_edge_needs_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_o && mode == MODE_EDGE) |-> pin_s_i != prev_q);
endmodule

// File: rtl/tamper_flag.sv
module tamper_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic evt_i,
  input  logic clear_i,
  input  logic irq_en_i,
  output logic flag_o,
  output logic irq_o
);
  logic flag_q;

  // event beats clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      flag_q <= 1'b0;
    else if (evt_i)   flag_q <= 1'b1;
    else if (clear_i) flag_q <= 1'b0;
  end

  assign flag_o = flag_q;
  assign irq_o  = flag_q & irq_en_i;

  a_r8_set_on_evt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i |=> flag_o);
  a_r8_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !clear_i) |=> flag_o);
  a_r8_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clear_i && !evt_i) |=> !flag_o);
  a_r9_irq_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (flag_o && irq_en_i));
endmodule

// File: rtl/tamper_detect.sv
module tamper_detect
  import tamper_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pin_i,
  input  logic              sample_i,
  input  logic              enable_i,
  input  logic              trig_i,
  input  logic [FILT_W-1:0] filt_i,
  input  logic              irq_en_i,
  input  logic              clear_i,
  output logic              flag_o,
  output logic              irq_o
);
  logic pin_s;
  logic evt;

  tamper_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pin_i),
    .q_o    (pin_s)
  );

  tamper_qual u_qual (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pin_s_i  (pin_s),
    .sample_i (sample_i),
    .enable_i (enable_i),
    .trig_i   (trig_i),
    .filt_i   (filt_i),
    .evt_o    (evt)
  );

  tamper_flag u_flag (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .evt_i    (evt),
    .clear_i  (clear_i),
    .irq_en_i (irq_en_i),
    .flag_o   (flag_o),
    .irq_o    (irq_o)
  );

  a_r2_flag_hold_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!enable_i && !clear_i) |=> $stable(flag_o));
  a_r9_flag_needs_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_o) |-> $past(enable_i));
endmodule

// File: tb/tb_tamper_detect.sv
module tb_tamper_detect;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pin = 1'b0, sample = 1'b0, en = 1'b0, trig = 1'b0, irq_en = 1'b0, clr = 1'b0;
  logic [1:0] filt = 2'd0;
  logic       flag, irq;

  int checks = 0;
  int errors = 0;
  bit rand_on = 1'b0;

  always #4 clk = ~clk;

  tamper_detect dut (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pin), .sample_i(sample), .enable_i(en),
    .trig_i(trig), .filt_i(filt), .irq_en_i(irq_en), .clear_i(clr),
    .flag_o(flag), .irq_o(irq)
  );

  // reference model built from the requirements
  logic m_s1, m_s2, m_prev, m_flag;
  int   m_run;

  function automatic int need_of(input logic [1:0] f);
    return 1 << f;
  endfunction

  function automatic bit event_of(input bit e, input logic [1:0] f, input bit t,
                                  input bit s2, input bit pv, input bit smp, input int run);
    if (!e) return 1'b0;
    if (f == 2'd0) return t ? (pv && !s2) : (!pv && s2);
    return smp && (s2 == t) && (run + 1 >= need_of(f));
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_prev = 0; m_flag = 0; m_run = 0;
    end else begin
      bit ev;
      ev = event_of(en, filt, trig, m_s2, m_prev, sample, m_run);
      if (!en || filt == 2'd0) m_run = 0;
      else if (sample) begin
        if (m_s2 != trig) m_run = 0;
        else if (m_run < need_of(filt)) m_run = m_run + 1;
      end
      if (ev) m_flag = 1;
      else if (clr) m_flag = 0;
      m_prev = m_s2; m_s2 = m_s1; m_s1 = pin;
    end
  end

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rand_on && rst_n) begin
    chk("R8", flag, m_flag);
    chk("R9", irq, m_flag & irq_en);
  end

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic strobe(input int n);
    for (int i = 0; i < n; i++) begin sample = 1; tick(); sample = 0; end
  endtask

  task automatic pulse_clear();
    clr = 1; tick(); clr = 0;
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    tick(3);
    chk("R1", flag, 1'b0);
    chk("R1", irq, 1'b0);
    rst_n = 1;
    tick(2);
    chk("R1", flag, 1'b0);

    // R10 / R3: rising edge, exact latency
    en = 1; filt = 0; trig = 0; pin = 0; tick(4);
    pin = 1; tick();
    chk("R10", flag, 1'b0);
    tick();
    chk("R10", flag, 1'b0);
    tick();
    chk("R3", flag, 1'b1);
    // R9
    chk("R9", irq, 1'b0);
    irq_en = 1; #1;
    chk("R9", irq, 1'b1);
    pulse_clear();
    chk("R8", flag, 1'b0);
    // R3: falling does not trigger
    pin = 0; tick(5);
    chk("R3", flag, 1'b0);

    // R4: falling edge
    en = 0; trig = 1; tick(); en = 1;
    pin = 1; tick(5);
    chk("R4", flag, 1'b0);
    pin = 0; tick(3);
    chk("R4", flag, 1'b1);
    chk("R9", irq, 1'b1);
    pulse_clear();

    // R2: disabled, nothing sets the flag
    en = 0;
    for (int i = 0; i < 6; i++) begin pin = ~pin; sample = 1; tick(3); end
    sample = 0;
    chk("R2", flag, 1'b0);
    // R2: disabled keeps an existing flag
    en = 1; trig = 0; pin = 0; tick(4); pin = 1; tick(3); en = 0;
    chk("R2", flag, 1'b1);
    pin = 0; tick(4); trig = 1; tick(2);
    chk("R2", flag, 1'b1);
    pulse_clear();

    // R5: active low, 2 samples
    trig = 0; filt = 1; pin = 0; tick(3); en = 1;
    strobe(1);
    chk("R5", flag, 1'b0);
    strobe(1);
    chk("R5", flag, 1'b1);
    pulse_clear();
    pin = 1; tick(3); strobe(3);
    chk("R5", flag, 1'b0);

    // R6 / R7: active high, 4 samples
    en = 0; trig = 1; filt = 2; tick(); en = 1;
    strobe(3);
    chk("R7", flag, 1'b0);
    strobe(1);
    chk("R6", flag, 1'b1);
    // R8: event and clear together
    clr = 1; sample = 1; tick(); clr = 0; sample = 0;
    chk("R8", flag, 1'b1);
    pulse_clear();

    // R7: 8 samples, broken run restarts
    en = 0; filt = 3; tick(); en = 1;
    strobe(7);
    chk("R7", flag, 1'b0);
    strobe(1);
    chk("R7", flag, 1'b1);
    pulse_clear();
    pin = 0; tick(3); strobe(1);
    pin = 1; tick(3); strobe(7);
    chk("R7", flag, 1'b0);
    strobe(1);
    chk("R7", flag, 1'b1);
    pulse_clear();
    // R9: irq_en does not stop the flag
    irq_en = 0; strobe(1);
    chk("R9", flag, 1'b1);
    chk("R9", irq, 1'b0);

    // random phase against the model
    rand_on = 1;
    for (int i = 0; i < 4000; i++) begin
      clr = 0;
      if ($urandom_range(0, 39) == 0) begin
        en = 0; tick();
        trig = 1'($urandom_range(0, 1));
        filt = 2'($urandom_range(0, 3));
        tick();
        en = 1'($urandom_range(0, 5) != 0);
      end
      if ($urandom_range(0, 5) == 0) pin = ~pin;
      sample = ($urandom_range(0, 2) == 0);
      clr    = ($urandom_range(0, 15) == 0);
      if ($urandom_range(0, 31) == 0) irq_en = ~irq_en;
      tick();
    end
    clr = 0; sample = 0;
    tick(2);
    rand_on = 0;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule